// File: doc/BRIEF.md
# Page Translation Lookaside Buffer

This block is a small, fully associative store of finished page translations. Each slot pairs a 20-bit virtual page number with a 20-bit physical frame number and carries a valid flag. A lookup key is compared against every slot at once. The hit flag and the frame number come back in the same cycle as the key, without passing through a register.

The fill port writes a translation that a page walker has just produced. Slots that have never been used since reset or since the last flush are taken one by one in slot order. Once every slot is valid, the slot that has gone unused the longest is overwritten. Lookup hits and fills both count as uses. A fill for a page that is already present rewrites that slot instead of making a second copy. The flush input empties the whole store in one cycle. It is meant to be pulsed when the translation table base changes.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss, with `lkp_hit` = 0 and `lkp_ppn` = 0.
- R2: With `lkp_vld` = 1, `lkp_hit` and `lkp_ppn` are a combinational function of `lkp_vpn` and the stored slots. On a match with a valid slot, `lkp_hit` = 1 and `lkp_ppn` is that slot's frame number. Otherwise both are 0.
- R3: While at least one slot is invalid, a fill writes the slot under the fill pointer and the pointer then steps forward. Fills after reset or flush therefore land in slots 0, 1, 2, 3 in that order, and with no lookups in between the first of them is the first to be evicted.
- R4: When every slot is valid, a fill of a new page overwrites the least recently used slot. Every other stored translation still hits afterwards.
- R5: A lookup hit makes its slot the most recently used. A fill makes its written slot the most recently used.
- R6: A fill whose page number matches a valid slot rewrites that slot's frame number in place. It occupies no other slot, so no other translation is lost.
- R7: A flush clears every valid flag at the next clock edge. It also returns the fill pointer to slot 0 and restores the initial usage order.
- R8: If flush and fill are both asserted in the same cycle, the flush wins and the fill is discarded.
- R9: A lookup in the same cycle as a fill sees the contents from before that edge. A lookup of the page being filled misses in that cycle and hits in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_vld | input | 1 | Lookup request in this cycle |
| lkp_vpn | input | 20 | Virtual page number to translate |
| lkp_hit | output | 1 | Lookup matched a valid slot |
| lkp_ppn | output | 20 | Physical frame number on a hit, 0 otherwise |
| fill_vld | input | 1 | Write a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number being written |
| fill_ppn | input | 20 | Physical frame number being written |
| flush | input | 1 | Invalidate all slots at the next edge |

## Verification
The assertions assume that nothing outside the block puts duplicate pages into the store. This holds because every fill is checked against the current contents first, so the parallel compare can find at most one match. They also assume that `lkp_vld` and `fill_vld` are never X after reset. The bench drives every input from its tasks on the falling edge, holding them at 0 when idle. Its keys come from a small pool, so that repeated pages, rewrites in place and evictions of a full store happen often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_VPN_W = 20;
  localparam int unsigned DEF_PPN_W = 20;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PPN_W = DEF_PPN_W,
  localparam int unsigned IW   = idx_width(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] slot_vld,
  input  logic [VPN_W-1:0] slot_vpn [SLOTS],
  input  logic [PPN_W-1:0] slot_ppn [SLOTS],
  input  logic [VPN_W-1:0] key,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic [PPN_W-1:0] hit_ppn
);
  logic [SLOTS-1:0] match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = slot_vld[g] && (slot_vpn[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i]) begin
        hit_idx = IW'(i);
        hit_ppn = hit_ppn | slot_ppn[i];
      end
    end
  end

  assign hit = |match;

  // R6: a page is never held in two valid slots
  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/tlb_age.sv
module tlb_age
  import tlb_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  localparam int unsigned IW   = idx_width(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(SLOTS - 1);

  logic [IW-1:0]    age_q [SLOTS];
  logic [SLOTS-1:0] is_oldest;

  for (genvar g = 0; g < SLOTS; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        age_q[g] <= IW'(SLOTS - 1 - g);
      end else if (touch) begin
        if (touch_idx == IW'(g))
          age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx])
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign is_oldest[g] = (age_q[g] == OLDEST);
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (is_oldest[i]) lru_idx = IW'(i);
  end

  // R5: a touched slot becomes the most recently used one
  p_touch_mru_r5: assert property (@(posedge clk) disable iff (rst)
    (touch && !clr) |=> (age_q[$past(touch_idx)] == '0));

  // R4: the usage order always names exactly one oldest slot
  p_one_oldest_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(is_oldest) == 1);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PPN_W = DEF_PPN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_vld,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             lkp_hit,
  output logic [PPN_W-1:0] lkp_ppn,
  input  logic             fill_vld,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);
  localparam int unsigned   IW   = idx_width(SLOTS);
  localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

  logic [SLOTS-1:0] vld_q;
  logic [VPN_W-1:0] vpn_q [SLOTS];
  logic [PPN_W-1:0] ppn_q [SLOTS];
  logic [IW-1:0]    ptr_q;

  logic             l_hit,  f_hit;
  logic [IW-1:0]    l_idx,  f_idx;
  logic [PPN_W-1:0] l_ppn,  f_ppn_unused;
  logic [IW-1:0]    lru_idx, victim;
  logic             full, do_fill, touch;
  logic [IW-1:0]    touch_idx;

  tlb_cam #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_lkp_cam (
    .clk(clk), .rst(rst), .slot_vld(vld_q), .slot_vpn(vpn_q),
    .slot_ppn(ppn_q), .key(lkp_vpn), .hit(l_hit), .hit_idx(l_idx),
    .hit_ppn(l_ppn));

  tlb_cam #(.SLOTS(SLOTS), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_fill_cam (
    .clk(clk), .rst(rst), .slot_vld(vld_q), .slot_vpn(vpn_q),
    .slot_ppn(ppn_q), .key(fill_vpn), .hit(f_hit), .hit_idx(f_idx),
    .hit_ppn(f_ppn_unused));

  assign full      = &vld_q;
  assign do_fill   = fill_vld && !flush;
  assign victim    = f_hit ? f_idx : (full ? lru_idx : ptr_q);
  assign lkp_hit   = lkp_vld && l_hit;
  assign lkp_ppn   = lkp_hit ? l_ppn : '0;
  assign touch     = do_fill || lkp_hit;
  assign touch_idx = do_fill ? victim : l_idx;

  tlb_age #(.SLOTS(SLOTS)) u_age (
    .clk(clk), .rst(rst), .clr(flush), .touch(touch),
    .touch_idx(touch_idx), .lru_idx(lru_idx));

  // valid flags and fill pointer
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (do_fill) begin
      vld_q[victim] <= 1'b1;
      if (!f_hit && !full)
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // translation storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (do_fill) begin
      vpn_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
    end
  end

  // R7: flush leaves no valid slot behind
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));

  // R3: a fresh page into a store with free slots moves the pointer by one
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (do_fill && !f_hit && !full) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R6: rewriting a present page keeps the valid count unchanged
  p_inplace_r6: assert property (@(posedge clk) disable iff (rst)
    (do_fill && f_hit) |=> ($countones(vld_q) == $countones($past(vld_q))));

  // R8: a fill dropped by flush leaves nothing valid
  p_flush_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (flush && fill_vld) |=> (vld_q == '0));

  // R2: a miss never drives a frame number
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !lkp_hit |-> (lkp_ppn == '0));
endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_vld = 1'b0;
  logic [19:0] lkp_vpn = '0;
  logic        lkp_hit;
  logic [19:0] lkp_ppn;
  logic        fill_vld = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xlat_tlb u_xlat_tlb (
    .clk(clk), .rst(rst), .lkp_vld(lkp_vld), .lkp_vpn(lkp_vpn),
    .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .fill_vld(fill_vld),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush));

  typedef struct {
    string       tag;
    logic        hit;
    logic [19:0] ppn;
  } exp_t;
  exp_t sb_q [$];

  // reference model built from the requirements
  bit          m_v   [4];
  logic [19:0] m_vpn [4];
  logic [19:0] m_ppn [4];
  int          m_ptr;
  int          m_order [$];  // front = most recent, back = oldest

  task automatic m_reset();
    for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
    m_ptr   = 0;
    m_order = '{3, 2, 1, 0};
  endtask

  task automatic m_touch(input int s);
    for (int i = 0; i < m_order.size(); i++)
      if (m_order[i] == s) begin
        m_order.delete(i);
        break;
      end
    m_order.push_front(s);
  endtask

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < 4; i++)
      if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic m_fill(input logic [19:0] v, input logic [19:0] p);
    int s;
    int n = 0;
    s = m_find(v);
    for (int i = 0; i < 4; i++) n += m_v[i];
    if (s < 0) begin
      if (n < 4) begin
        s = m_ptr;
        m_ptr = (m_ptr + 1) % 4;
      end else begin
        s = m_order[m_order.size()-1];
      end
    end
    m_v[s] = 1'b1;
    m_vpn[s] = v;
    m_ppn[s] = p;
    m_touch(s);
  endtask

  // driver: one cycle of stimulus
  task automatic step(input bit lv, input logic [19:0] lvpn,
                      input bit fv, input logic [19:0] fvpn,
                      input logic [19:0] fppn, input bit fl,
                      input string tag);
    exp_t e;
    int   s;
    @(negedge clk);
    lkp_vld = lv; lkp_vpn = lvpn;
    fill_vld = fv; fill_vpn = fvpn; fill_ppn = fppn;
    flush = fl;
    s = m_find(lvpn);
    if (lv) begin
      e.tag = tag;
      e.hit = (s >= 0);
      e.ppn = (s >= 0) ? m_ppn[s] : 20'h0;
      sb_q.push_back(e);
    end
    if (fl)            m_reset();
    else if (fv)       m_fill(fvpn, fppn);
    else if (lv && s >= 0) m_touch(s);
  endtask

  task automatic look(input logic [19:0] v, input string tag);
    step(1'b1, v, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic put(input logic [19:0] v, input logic [19:0] p);
    step(1'b0, '0, 1'b1, v, p, 1'b0, "");
  endtask
  task automatic do_flush();
    step(1'b0, '0, 1'b0, '0, '0, 1'b1, "");
  endtask
  task automatic idle();
    step(1'b0, '0, 1'b0, '0, '0, 1'b0, "");
  endtask

  // monitor: compares outputs in the low phase
  always @(negedge clk) begin
    exp_t e;
    #2;
    if (lkp_vld && !rst) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual hit=%0b ppn=%05h expected none",
                 lkp_hit, lkp_ppn);
      end else begin
        e = sb_q.pop_front();
        checks++;
        if (lkp_hit !== e.hit || lkp_ppn !== e.ppn) begin
          errors++;
          $display("FAIL %s: actual hit=%0b ppn=%05h expected hit=%0b ppn=%05h",
                   e.tag, lkp_hit, lkp_ppn, e.hit, e.ppn);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look(20'h00000, "R1 reset miss");
    look(20'h12345, "R1 reset miss");

    // R3: ordered fills, R2: hits
    put(20'h00003, 20'h00005);
    put(20'h00007, 20'h00009);
    put(20'h00009, 20'h00001);
    put(20'h0000B, 20'h00003);
    look(20'h00003, "R2 hit");
    look(20'h00007, "R2 hit");
    look(20'h00009, "R2 hit");
    look(20'h0000B, "R2 hit");
    look(20'h0000D, "R2 miss");

    // R4: full store evicts oldest
    put(20'h0000D, 20'h0000A);
    look(20'h00003, "R4 oldest evicted");
    look(20'h0000D, "R4 new entry");
    look(20'h00007, "R4 survivor");

    // R5: hit keeps 00007 young, next eviction takes 00009
    put(20'h00011, 20'h00022);
    look(20'h00009, "R5 oldest evicted");
    look(20'h00007, "R5 recent kept");
    look(20'h0000B, "R5 survivor");

    // R6: rewrite in place
    put(20'h00007, 20'h0ABCD);
    look(20'h00007, "R6 new frame");
    look(20'h0000D, "R6 no loss");
    look(20'h00011, "R6 no loss");
    look(20'h0000B, "R6 no loss");

    // R7: flush clears everything
    do_flush();
    look(20'h00007, "R7 flushed");
    look(20'h0000B, "R7 flushed");

    // R3: after flush fills restart at slot 0, first fill evicted first
    put(20'hFFFFF, 20'hFFFFF);
    put(20'h00000, 20'h0000A);
    put(20'h00001, 20'h12345);
    put(20'h00004, 20'h00003);
    put(20'h00020, 20'h00040);
    look(20'hFFFFF, "R3 first fill evicted");
    look(20'h00000, "R3 kept");
    look(20'h00020, "R3 newest");

    // R8: flush beats fill
    step(1'b0, '0, 1'b1, 20'h11111, 20'h22222, 1'b1, "");
    look(20'h11111, "R8 fill dropped");
    look(20'h00000, "R8 flushed");

    // R9: lookup sees contents from before the fill edge
    step(1'b1, 20'h22222, 1'b1, 20'h22222, 20'h33333, 1'b0, "R9 same cycle miss");
    look(20'h22222, "R9 next cycle hit");

    // mixed traffic over a small key pool
    for (int k = 0; k < 400; k++) begin
      logic [19:0] kv, fv;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      kv = 20'(lfsr[2:0]) + 20'h100;
      fv = 20'(lfsr[6:4]) + 20'h100;
      step(lfsr[8], kv, lfsr[9] & lfsr[10], fv, 20'(lfsr) ^ 20'h5A5A5,
           (lfsr[15:11] == 5'h1F), "R2 R4 R5 R6 mixed");
    end

    idle();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule